// File: doc/BRIEF.md
# Page-Write Buffer and Write-Cycle Sequencer

This block sits behind a two-wire serial memory's bus protocol engine and in front of a 128-byte storage array. The array is modelled here as a register file. The protocol engine tells the block what happened on the bus through single-cycle strobes:

- an address was loaded;
- a data byte arrived;
- a read byte was consumed;
- a stop condition was seen.

The block holds the internal address pointer and a four-byte page latch, with one valid flag per latched byte. It turns a completed write transaction into one timed commit.

Incoming write bytes land in the page latch. Only the two low pointer bits step between bytes, so a long burst wraps inside its four-byte page and overwrites earlier bytes. Reads step the full seven-bit pointer and roll over at the top of the array.

A stop after at least one data byte starts the commit, but only when the write-lock pin is low. The busy flag stays high for a parameterised number of clocks, and the whole block ignores its strobes during that time. In the last busy cycle, exactly the latched bytes are written to the array, and the write mask shows which page lanes are being written.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, the pointer is 0, busy is low, the write mask is 0, and every array byte reads as 0x00. This means rdData shows 0x00.
- R2: An address-load strobe copies addrIn into the pointer, and rdData then shows the array byte at that address.
- R3: Each accepted data byte is latched into page lane pointer[1:0]. After the byte, pointer[1:0] increments modulo 4 while pointer[6:2] stays fixed.
- R4: A fifth or later byte in one transaction wraps to a lane already used, and the newer byte replaces the one latched there earlier.
- R5: A read-advance strobe increments all seven pointer bits, so the pointer goes from 127 to 0 and crosses page boundaries.
- R6: A stop strobe with at least one latched byte, the lock low and busy low raises busy on the next cycle. Busy then stays high for exactly WR_CYCLES cycles.
- R7: A commit writes only the lanes that received a byte, at page base pointer[6:2]. The other bytes of that page keep their contents.
- R8: If writeLock is high when the stop strobe arrives, busy stays low, the array is unchanged and the latched bytes are discarded.
- R9: A stop with no latched byte starts no write cycle, and the pointer keeps the loaded address.
- R10: While busy is high, address-load, data, read-advance and stop strobes have no effect on the pointer, the latch or the array.
- R11: After a commit, the pointer is left one past the last latched lane, wrapping within the page. A read without a new address load therefore returns that byte.
- R12: arrWrMask is nonzero only in the final busy cycle, and bit i is set exactly when lane i is written then.
- R13: An address load discards any bytes latched earlier, so a following stop starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrLoadStb | input | 1 | Load pointer from addrIn |
| addrIn | input | 7 | Word address from the protocol engine |
| dataStb | input | 1 | A write data byte is present on dataIn |
| dataIn | input | 8 | Write data byte |
| readAdvStb | input | 1 | The read byte was consumed, so advance the pointer |
| stopStb | input | 1 | A stop condition was seen on the bus |
| writeLock | input | 1 | High blocks all writes to the array |
| rdData | output | 8 | Array byte at the current pointer |
| busy | output | 1 | A write cycle is in progress |
| arrWrMask | output | 4 | Lanes written to the array this cycle |

## Verification
The bench builds the block with WR_CYCLES set to 12 instead of a multi-millisecond count. The exact busy length, the single-cycle write mask at its end and strobes that arrive during busy can then all be observed within a few dozen clocks per transaction. The default widths are kept, so the full 128-byte array is present. This puts the pointer's 127-to-0 rollover and a five-byte page wrap within reach of a direct test.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Strobes from control to datapath, all already gated by busy.
  typedef struct packed {
    logic loadAddr;
    logic latchByte;
    logic advRead;
    logic commit;
    logic clearValid;
  } ctlStrobes_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int PAGE_N    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoadStb,
  input  logic              dataStb,
  input  logic              readAdvStb,
  input  logic              stopStb,
  input  logic              writeLock,
  input  logic [PAGE_N-1:0] pageValid,
  output logic              busy,
  output ctlStrobes_t       stb
);
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cycCnt;
  logic startWrite;
  logic idleStop;

  assign idleStop   = stopStb && !busy;
  assign startWrite = idleStop && (|pageValid) && !writeLock;

  always_comb begin
    stb.loadAddr   = addrLoadStb && !busy;
    stb.latchByte  = dataStb && !busy;
    stb.advRead    = readAdvStb && !busy;
    stb.commit     = busy && (cycCnt == LAST);
    stb.clearValid = stb.commit || (idleStop && writeLock);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cycCnt <= '0;
    end else if (startWrite) begin
      busy   <= 1'b1;
      cycCnt <= '0;
    end else if (stb.commit) begin
      busy   <= 1'b0;
      cycCnt <= '0;
    end else if (busy) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcu_dpath.sv
module pcu_dpath
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [(1<<PAGE_W)-1:0] pageValid,
  output logic [DATA_W-1:0] rdData,
  output logic [(1<<PAGE_W)-1:0] arrWrMask
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] latch [PAGE_N];
  logic [PAGE_W-1:0] lane;
  logic [ADDR_W-PAGE_W-1:0] pageBase;

  assign lane     = curAddr[PAGE_W-1:0];
  assign pageBase = curAddr[ADDR_W-1:PAGE_W];

  // Pointer: load wins, then page-local step, then full step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curAddr <= '0;
    else if (stb.loadAddr) curAddr <= addrIn;
    else if (stb.latchByte) curAddr <= {pageBase, PAGE_W'(lane + 1'b1)};
    else if (stb.advRead) curAddr <= curAddr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageValid <= '0;
    else if (stb.clearValid || stb.loadAddr) pageValid <= '0;
    else if (stb.latchByte) pageValid[lane] <= 1'b1;
  end

  generate
    for (genvar g = 0; g < PAGE_N; g++) begin : gLane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latch[g] <= '0;
        else if (stb.latchByte && !stb.loadAddr && lane == PAGE_W'(g)) latch[g] <= dataIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (stb.commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (pageValid[i]) mem[{pageBase, PAGE_W'(i)}] <= latch[i];
    end
  end

  assign rdData    = mem[curAddr];
  assign arrWrMask = stb.commit ? pageValid : '0;
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoadStb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              readAdvStb,
  input  logic              stopStb,
  input  logic              writeLock,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic [(1<<PAGE_W)-1:0] arrWrMask
);
  localparam int PAGE_N = 1 << PAGE_W;

  ctlStrobes_t       stb;
  logic [PAGE_N-1:0] pageValid;
  logic [ADDR_W-1:0] curAddr;

  pcu_ctrl #(.PAGE_N(PAGE_N), .WR_CYCLES(WR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .addrLoadStb(addrLoadStb), .dataStb(dataStb),
    .readAdvStb(readAdvStb), .stopStb(stopStb), .writeLock(writeLock),
    .pageValid(pageValid), .busy(busy), .stb(stb)
  );

  pcu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addrIn(addrIn), .dataIn(dataIn),
    .curAddr(curAddr), .pageValid(pageValid), .rdData(rdData), .arrWrMask(arrWrMask)
  );
endmodule

// File: rtl/page_commit_unit_chk.sv
module page_commit_unit_chk #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 625000
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataStb,
  input logic              stopStb,
  input logic              writeLock,
  input logic              busy,
  input logic [ADDR_W-1:0] curAddr,
  input logic [(1<<PAGE_W)-1:0] pageValid,
  input logic [(1<<PAGE_W)-1:0] arrWrMask
);
  localparam int CW = $clog2(WR_CYCLES + 2);
  logic [CW-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R6: a valid stop with the lock low starts the write cycle
  a_r6_busy_starts: assert property (@(posedge clk) disable iff (!rstN)
    stopStb && !busy && (|pageValid) && !writeLock |=> busy);

  // R6: busy never lasts longer than the configured cycle count
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < CW'(WR_CYCLES));

  // R8: the lock prevents a write cycle from starting
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    stopStb && !busy && writeLock |=> !busy);

  // R9: a stop with nothing latched starts nothing
  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopStb && !busy && (pageValid == '0) |=> !busy);

  // R10: the pointer is frozen while a write cycle runs
  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr));

  // R12: the write mask appears only inside a write cycle
  a_r12_mask_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|arrWrMask) |-> busy);

  // R3: a page byte moves only the low pointer bits
  a_r3_page_step: assert property (@(posedge clk) disable iff (!rstN)
    dataStb && !busy |=> (curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W]))
      && (curAddr[PAGE_W-1:0] == PAGE_W'($past(curAddr[PAGE_W-1:0]) + 1'b1)));
endmodule

bind page_commit_unit page_commit_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .dataStb(dataStb & ~addrLoadStb), .stopStb(stopStb),
  .writeLock(writeLock), .busy(busy), .curAddr(curAddr), .pageValid(pageValid),
  .arrWrMask(arrWrMask)
);

// File: tb/page_commit_unit_test.sv
module page_commit_unit_test;
  localparam int WRC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrLoadStb = 0, dataStb = 0, readAdvStb = 0, stopStb = 0, writeLock = 0;
  logic [6:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] rdData;
  logic busy;
  logic [3:0] arrWrMask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t expQ[$];
  logic monTake = 0;

  always #4 clk = ~clk;

  page_commit_unit #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rstN(rstN), .addrLoadStb(addrLoadStb), .addrIn(addrIn),
    .dataStb(dataStb), .dataIn(dataIn), .readAdvStb(readAdvStb), .stopStb(stopStb),
    .writeLock(writeLock), .rdData(rdData), .busy(busy), .arrWrMask(arrWrMask)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read byte and compares it away from the edge.
  always @(negedge clk) begin
    if (monTake && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check({24'd0, rdData}, {24'd0, it.exp}, it.tag);
    end
  end

  task automatic loadAddr(input logic [6:0] a);
    @(posedge clk); #1 addrLoadStb = 1; addrIn = a;
    @(posedge clk); #1 addrLoadStb = 0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(posedge clk); #1 dataStb = 1; dataIn = d;
    @(posedge clk); #1 dataStb = 0;
  endtask

  // Driver: pushes the expected byte, then consumes it with a read advance.
  task automatic readByte(input logic [7:0] exp, input string tag);
    @(posedge clk); #1 expQ.push_back('{exp, tag}); monTake = 1; readAdvStb = 1;
    @(posedge clk); #1 monTake = 0; readAdvStb = 0;
  endtask

  // Issue stop and measure the busy run and the mask seen during it.
  task automatic stopAndWait(input int expLen, input logic [3:0] expMask, input string tag);
    int len = 0;
    logic [3:0] seen = '0;
    int maskCycles = 0;
    @(posedge clk); #1 stopStb = 1;
    @(posedge clk); #1 stopStb = 0;
    for (int k = 0; k < WRC + 8; k++) begin
      @(negedge clk);
      if (!busy) break;
      len++;
      if (arrWrMask != 0) begin seen = arrWrMask; maskCycles++; end
    end
    check(len, expLen, {tag, " busy length"});
    check({28'd0, seen}, {28'd0, expMask}, {tag, " write mask"});
    check(maskCycles, (expMask != 0) ? 1 : 0, {tag, " mask cycles"});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(busy, 0, "R1 busy after reset");
    check(arrWrMask, 0, "R1 mask after reset");
    check(rdData, 8'h00, "R1 rdData after reset");

    // R6 R7 R12 R11: two-byte write at 0x10
    loadAddr(7'h10);
    sendByte(8'hA0);
    sendByte(8'hA1);
    stopAndWait(WRC, 4'b0011, "R6 R12 two-byte");
    readByte(8'h00, "R11 pointer at 0x12 after commit");
    loadAddr(7'h10);
    readByte(8'hA0, "R2 R7 byte 0x10");
    readByte(8'hA1, "R7 byte 0x11");
    readByte(8'h00, "R7 untouched 0x12");
    readByte(8'h00, "R7 untouched 0x13");

    // R3 R4: five bytes from 0x25, wrap inside page 0x24
    loadAddr(7'h25);
    sendByte(8'hB0); sendByte(8'hB1); sendByte(8'hB2); sendByte(8'hB3); sendByte(8'hB4);
    stopAndWait(WRC, 4'b1111, "R4 wrap");
    readByte(8'hB1, "R11 R3 pointer lane 2 after wrap");
    loadAddr(7'h24);
    readByte(8'hB3, "R4 lane0");
    readByte(8'hB4, "R4 lane1 overwritten");
    readByte(8'hB1, "R3 lane2");
    readByte(8'hB2, "R3 lane3");
    readByte(8'h00, "R3 next page untouched 0x28");

    // R8: lock blocks the write
    writeLock = 1;
    loadAddr(7'h40);
    sendByte(8'h55);
    stopAndWait(0, 4'b0000, "R8 locked");
    writeLock = 0;
    stopAndWait(0, 4'b0000, "R8 latch discarded");
    loadAddr(7'h40);
    readByte(8'h00, "R8 array unchanged");

    // R9: stop with no data keeps the loaded address
    loadAddr(7'h25);
    stopAndWait(0, 4'b0000, "R9 empty stop");
    readByte(8'hB4, "R9 pointer kept");

    // R13: a new address load discards latched bytes
    loadAddr(7'h60);
    sendByte(8'h77);
    loadAddr(7'h61);
    stopAndWait(0, 4'b0000, "R13 discard");
    loadAddr(7'h60);
    readByte(8'h00, "R13 array unchanged");

    // R5: full pointer rollover 127 -> 0
    loadAddr(7'h00);
    sendByte(8'h9A);
    stopAndWait(WRC, 4'b0001, "R5 setup");
    loadAddr(7'h7E);
    readByte(8'h00, "R5 byte 0x7E");
    readByte(8'h00, "R5 byte 0x7F");
    readByte(8'h9A, "R5 rollover to 0x00");

    // R10: strobes during busy are ignored
    loadAddr(7'h30);
    sendByte(8'h11);
    @(posedge clk); #1 stopStb = 1;
    @(posedge clk); #1 stopStb = 0;
    @(negedge clk);
    check(busy, 1, "R10 busy raised");
    @(posedge clk); #1 addrLoadStb = 1; addrIn = 7'h00;
    @(posedge clk); #1 addrLoadStb = 0; dataStb = 1; dataIn = 8'h22;
    @(posedge clk); #1 dataStb = 0; readAdvStb = 1;
    @(posedge clk); #1 readAdvStb = 0;
    for (int k = 0; k < WRC + 4; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    check(busy, 0, "R10 busy cleared");
    readByte(8'h00, "R10 pointer still 0x31");
    loadAddr(7'h30);
    readByte(8'h11, "R10 byte 0x30 committed");
    readByte(8'h00, "R10 data during busy dropped");

    repeat (2) @(negedge clk);
    check(expQ.size(), 0, "scoreboard drained");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule